// File: doc/BRIEF.md
# Routed Event Synchronisation Network

This block gathers single-cycle event pulses from a set of producers (processors, accelerator bridges, a DMA engine) that fire whenever the token count of a dataflow channel moves. A programmable routing matrix, one source-select mask per consumer, picks which producers concern each consumer. The selected pulses are ORed and latched into a per-consumer pending flag.

Handling is deferred rather than forced. A pending flag stays set until its consumer clears it on purpose, so no context switch ever happens. A consumer that has nothing to do can ask to sleep. It stays in its idle state until a routed event arrives. A one-cycle wake pulse then releases it in the cycle after the event.

Top module: `evt_route_net`

## Requirements
- R1: For each destination d, if any source i has src_evt_i[i] high while bit i of d's mask is set in a cycle, pending_o[d] is high from the next cycle on.
- R2: Mask bit i selects source i. Masks reset to all zero. A write with cfg_we_i high loads cfg_mask_i into the mask of destination cfg_dst_i and governs events from the following cycle; an event in the write cycle still uses the old mask.
- R3: A pending flag stays set for as long as no clear request is given for it.
- R4: With clr_i[d] high and no routed event for d in the same cycle, pending_o[d] is low in the next cycle.
- R5: With clr_i[d] high and a routed event for d in the same cycle, pending_o[d] stays high in the next cycle.
- R6: wake_o[d] is high for exactly the cycle after each cycle in which a routed event for d is seen, and low otherwise.
- R7: With wait_i[d] high, nothing pending for d and no routed event for d, idle_o[d] is high from the next cycle on. It holds there until a routed event arrives, whatever wait_i[d] does.
- R8: idle_o[d] drops in the same cycle as wake_o[d] rises. A wait request made while d has an event pending is ignored, so idle_o[d] and pending_o[d] are never both high.
- R9: After reset, every pending flag, wake pulse and idle flag is low.
- R10: Events from sources whose mask bit is clear have no effect on a destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_evt_i | input | N_SRC | Event pulses, one per source |
| cfg_we_i | input | 1 | Mask write strobe |
| cfg_dst_i | input | DST_W | Destination index for a mask write |
| cfg_mask_i | input | N_SRC | Mask value to write |
| clr_i | input | N_DST | Clear request per destination |
| wait_i | input | N_DST | Request to enter idle, per destination |
| pending_o | output | N_DST | Latched event status per destination |
| wake_o | output | N_DST | One-cycle wake pulse per destination |
| idle_o | output | N_DST | Destination is sleeping |

## Verification
A wrong mask bit or a stuck pending register shows at pending_o exactly one cycle after the source pulse that should or should not have reached it. A missing or extra wake pulse shows on the same edge. A faulty idle state machine shows as idle_o staying high beside a set pending flag, or failing to drop at the wake edge. Priority between clear and event is exposed by driving both in one cycle and reading pending_o on the next.

// File: rtl/evt_pkg.sv
package evt_pkg;
  typedef enum logic {
    DST_RUN  = 1'b0,
    DST_IDLE = 1'b1
  } dst_mode_e;
endpackage

// File: rtl/evt_mask_bank.sv
module evt_mask_bank #(
  parameter int N_SRC = 8,
  parameter int N_DST = 4,
  parameter int DST_W = (N_DST > 1) ? $clog2(N_DST) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_evt_i,
  input  logic             cfg_we_i,
  input  logic [DST_W-1:0] cfg_dst_i,
  input  logic [N_SRC-1:0] cfg_mask_i,
  output logic [N_DST-1:0] hit_o
);
  logic [N_SRC-1:0] mask_q [N_DST];

  for (genvar d = 0; d < N_DST; d++) begin : g_dst
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   mask_q[d] <= '0;
      else if (cfg_we_i && cfg_dst_i == DST_W'(d))   mask_q[d] <= cfg_mask_i;
    end
    assign hit_o[d] = |(src_evt_i & mask_q[d]);
  end
endmodule

// File: rtl/evt_dst_slot.sv
module evt_dst_slot
  import evt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic clr_i,
  input  logic wait_i,
  output logic pending_o,
  output logic wake_o,
  output logic idle_o
);
  logic      pend_q, wake_q;
  dst_mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (hit_i)                        mode_d = DST_RUN;
    else if (wait_i && !pend_q)       mode_d = DST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      wake_q <= 1'b0;
      mode_q <= DST_RUN;
    end else begin
      pend_q <= hit_i | (pend_q & ~clr_i);  // new event outranks clear
      wake_q <= hit_i;
      mode_q <= mode_d;
    end
  end

  assign pending_o = pend_q;
  assign wake_o    = wake_q;
  assign idle_o    = (mode_q == DST_IDLE);
endmodule

// File: rtl/evt_route_net.sv
module evt_route_net #(
  parameter int N_SRC = 8,
  parameter int N_DST = 4,
  parameter int DST_W = (N_DST > 1) ? $clog2(N_DST) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_evt_i,
  input  logic             cfg_we_i,
  input  logic [DST_W-1:0] cfg_dst_i,
  input  logic [N_SRC-1:0] cfg_mask_i,
  input  logic [N_DST-1:0] clr_i,
  input  logic [N_DST-1:0] wait_i,
  output logic [N_DST-1:0] pending_o,
  output logic [N_DST-1:0] wake_o,
  output logic [N_DST-1:0] idle_o
);
  logic [N_DST-1:0] dst_hit;

  evt_mask_bank #(.N_SRC(N_SRC), .N_DST(N_DST), .DST_W(DST_W)) u_mask (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .src_evt_i (src_evt_i),
    .cfg_we_i  (cfg_we_i),
    .cfg_dst_i (cfg_dst_i),
    .cfg_mask_i(cfg_mask_i),
    .hit_o     (dst_hit)
  );

  for (genvar d = 0; d < N_DST; d++) begin : g_slot
    evt_dst_slot u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .hit_i    (dst_hit[d]),
      .clr_i    (clr_i[d]),
      .wait_i   (wait_i[d]),
      .pending_o(pending_o[d]),
      .wake_o   (wake_o[d]),
      .idle_o   (idle_o[d])
    );
  end
endmodule

// File: rtl/evt_route_net_chk.sv
module evt_route_net_chk #(
  parameter int N_DST = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_DST-1:0] hit_i,
  input logic [N_DST-1:0] clr_i,
  input logic [N_DST-1:0] wait_i,
  input logic [N_DST-1:0] pending_o,
  input logic [N_DST-1:0] wake_o,
  input logic [N_DST-1:0] idle_o
);
  for (genvar d = 0; d < N_DST; d++) begin : g_chk
    p_event_latch_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_i[d] |=> pending_o[d]);
    p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pending_o[d] && !clr_i[d]) |=> pending_o[d]);
    p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[d] && !hit_i[d]) |=> !pending_o[d]);
    p_wake_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_i[d] |=> wake_o[d]);
    p_no_stray_wake_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !hit_i[d] |=> !wake_o[d]);
    p_idle_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (idle_o[d] && !hit_i[d]) |=> idle_o[d]);
    p_idle_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(idle_o[d] && pending_o[d]));
    p_wake_exit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wake_o[d] |-> !idle_o[d]);
  end
endmodule

bind evt_route_net evt_route_net_chk #(.N_DST(N_DST)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .hit_i    (dst_hit),
  .clr_i    (clr_i),
  .wait_i   (wait_i),
  .pending_o(pending_o),
  .wake_o   (wake_o),
  .idle_o   (idle_o)
);

// File: tb/sim_evt_route_net.sv
module sim_evt_route_net;
  localparam int N_SRC = 8;
  localparam int N_DST = 4;
  localparam int DST_W = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [N_SRC-1:0] src_evt = '0;
  logic             cfg_we = 1'b0;
  logic [DST_W-1:0] cfg_dst = '0;
  logic [N_SRC-1:0] cfg_mask = '0;
  logic [N_DST-1:0] clr = '0;
  logic [N_DST-1:0] wt = '0;
  logic [N_DST-1:0] pending, wake, idle;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  evt_route_net #(.N_SRC(N_SRC), .N_DST(N_DST)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_evt_i(src_evt), .cfg_we_i(cfg_we),
    .cfg_dst_i(cfg_dst), .cfg_mask_i(cfg_mask), .clr_i(clr), .wait_i(wt),
    .pending_o(pending), .wake_o(wake), .idle_o(idle)
  );

  // {src, clr, wait, exp_pending, exp_wake, exp_idle}
  // masks: d0=03 d1=0C d2=81 d3=00
  localparam logic [27:0] VEC [12] = '{
    {8'h00, 4'h0, 4'hF, 4'h0, 4'h0, 4'hF},  // R7 all enter idle
    {8'h01, 4'h0, 4'h0, 4'h5, 4'h5, 4'hA},  // R1 R6 R8 fan-out to d0,d2
    {8'h00, 4'h0, 4'h0, 4'h5, 4'h0, 4'hA},  // R3 R6 R7 hold
    {8'h04, 4'h1, 4'h0, 4'h6, 4'h2, 4'h8},  // R4 clear d0, R1 d1
    {8'h02, 4'h0, 4'h0, 4'h7, 4'h1, 4'h8},  // R1 d0 again
    {8'h02, 4'h1, 4'h0, 4'h7, 4'h1, 4'h8},  // R5 clear vs event
    {8'hF0, 4'h4, 4'h0, 4'h7, 4'h4, 4'h8},  // R5 R10 d2 via bit 7 only
    {8'h00, 4'hF, 4'h0, 4'h0, 4'h0, 4'h8},  // R4 clear all
    {8'hFF, 4'h0, 4'h0, 4'h7, 4'h7, 4'h8},  // R10 d3 unrouted stays idle
    {8'h00, 4'h7, 4'h7, 4'h0, 4'h0, 4'h8},  // R8 wait ignored while pending
    {8'h00, 4'h0, 4'h1, 4'h0, 4'h0, 4'h9},  // R7 d0 sleeps
    {8'h08, 4'h0, 4'h0, 4'h2, 4'h2, 4'h9}   // R7 R10 d1 wakes, d0 stays
  };

  task automatic chk(input string req, input string what,
                     input logic [3:0] act, input logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr_mask(input int d, input logic [7:0] m);
    cfg_we = 1'b1; cfg_dst = DST_W'(d); cfg_mask = m;
    tick();
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (3) tick();
    chk("R9", "pending at reset", pending, 4'h0);
    chk("R9", "wake at reset", wake, 4'h0);
    chk("R9", "idle at reset", idle, 4'h0);
    rst_n = 1'b1;
    tick();
    src_evt = 8'hFF;  // R2 masks zero after reset: nothing routed
    tick();
    chk("R2", "pending with reset masks", pending, 4'h0);
    src_evt = '0;
    wr_mask(0, 8'h03); wr_mask(1, 8'h0C); wr_mask(2, 8'h81); wr_mask(3, 8'h00);
    foreach (VEC[k]) begin
      src_evt = VEC[k][27:20]; clr = VEC[k][19:16]; wt = VEC[k][15:12];
      tick();
      chk("R1 R3 R4 R5 R7 R8 R10", $sformatf("vec %0d pending", k), pending, VEC[k][11:8]);
      chk("R6", $sformatf("vec %0d wake", k), wake, VEC[k][7:4]);
      chk("R7 R8", $sformatf("vec %0d idle", k), idle, VEC[k][3:0]);
    end
    src_evt = '0; clr = '0; wt = '0;
    tick();
    chk("R6", "wake single cycle", wake, 4'h0);
    // R2 event in write cycle uses old mask (d3 mask 00)
    cfg_we = 1'b1; cfg_dst = 2'd3; cfg_mask = 8'h20; src_evt = 8'h20;
    tick();
    cfg_we = 1'b0;
    chk("R2", "old mask in write cycle", pending, 4'h2);
    chk("R2", "d3 still idle", idle, 4'h9);
    tick();  // src still 20, new mask applies
    chk("R2", "new mask routes", pending, 4'hA);
    chk("R8", "d3 leaves idle with wake", idle, 4'h1);
    chk("R6", "d3 wake", wake, 4'h8);
    src_evt = '0;
    tick();
    // R9 async reset mid-run
    #1 rst_n = 1'b0;
    #1 chk("R9", "pending after async reset", pending, 4'h0);
    chk("R9", "idle after async reset", idle, 4'h0);
    tick();
    rst_n = 1'b1;
    src_evt = 8'h20;
    tick();
    chk("R2", "mask cleared by reset", pending, 4'h0);
    src_evt = '0;
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule